// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block is the receive side of a framed synchronous serial port. Three pins enter from outside: a bit clock, a frame marker and a data line. All three are brought into the system clock domain by a synchronizer, and the receiver acts on each falling edge of the bit clock it sees there. A rising frame marker starts a word. After a programmable delay of zero, one or two bit periods, the receiver collects a fixed number of bits, most significant bit first.

A completed word travels through three registers: the shift register, a one-word holding buffer and the host register that software or a DMA engine reads. When the host register fills, a level flag and a one-cycle event are raised. A read strobe empties the host register, and the buffered word then moves up into it. A word that completes while both the buffer and the host register are occupied is dropped and latches an overrun flag. A frame marker that arrives in the middle of a word restarts reception and latches a sync-error flag.

A mode input turns the receiver off and hands the synchronized pin levels to software as plain inputs.

Top module: `rxs_receiver`

## Requirements
- R1: After reset, `rx_data` is zero and `rx_ready`, `rx_event`, `overrun` and `sync_err` are all low.
- R2: A word of `WORD_BITS` bits is assembled most significant bit first and appears on `rx_data` with `rx_ready` high.
- R3: A data bit is taken at the falling edge of the bit clock. A line that changes just after each rising edge is therefore received without error.
- R4: With `delay_sel` = 0, the bit present at the falling edge where the frame marker is first seen high is the most significant bit.
- R5: With `delay_sel` = 1 or 2, the most significant bit comes that many bit periods after the marker edge. Code 3 behaves as code 2, and the bits inside the delay are discarded.
- R6: A one-cycle `rd_en` empties the host register, and `rx_ready` drops unless a buffered word is waiting. A buffered word moves into the host register with a one-cycle `rx_event`.
- R7: A word that completes while both the buffer and the host register are full is dropped and sets the sticky `overrun` flag. The two stored words are kept.
- R8: A word that completes in the same cycle as a `rd_en` does not set `overrun`. The buffered word moves up to the host register and the new word takes its place.
- R9: A rising frame marker before the current word is complete restarts reception and sets the sticky `sync_err` flag. The restarted word is received intact.
- R10: While `gpio_mode` is high, no word is received. `gpio_in` carries the synchronized pin levels as {frame, data, clock} (bit 2 = frame, bit 0 = clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk_pin | input | 1 | Serial bit clock |
| rx_fs_pin | input | 1 | Frame marker |
| rx_dat_pin | input | 1 | Serial data |
| delay_sel | input | 2 | Bit periods between marker and MSB (3 acts as 2) |
| gpio_mode | input | 1 | Receiver off; pins readable as plain inputs |
| rd_en | input | 1 | One-cycle host read strobe |
| rx_data | output | WORD_BITS | Host register contents |
| rx_ready | output | 1 | Host register holds an unread word |
| rx_event | output | 1 | One-cycle pulse when the host register is loaded |
| overrun | output | 1 | Sticky: a completed word was dropped |
| sync_err | output | 1 | Sticky: frame marker arrived mid-word |
| gpio_in | output | 3 | Synchronized pin levels {frame, data, clock} |

## Verification
A word can complete in the same cycle as a host read. That read frees the host register, so the read must keep the new word from being counted as an overrun. The bench fills both the buffer and the host register, then sends a third word. It raises `rd_en` for exactly the cycle in which that word reaches the buffer, a cycle it derives from the synchronizer depth and the register count. The result is judged at the ports: `overrun` must stay low, and two further reads must return the second and third words in order. The plain overrun case, which has no read, serves as the contrast.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_DATA  = 2'd2
  } rx_state_t;

  // Code 3 is treated as the longest legal delay (2 bit periods).
  function automatic logic [1:0] eff_delay(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/rxs_edge.sv
module rxs_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] pins_in,   // {frame, data, clock}
  output logic [2:0] pins_s,
  output logic       fall_stb,
  output logic [2:0] gp_q
);

  logic [SYNC_STAGES-1:0][2:0] stg;
  logic                        clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg      <= '0;
      clk_prev <= 1'b0;
      gp_q     <= '0;
    end else begin
      stg      <= {stg[SYNC_STAGES-2:0], pins_in};
      clk_prev <= stg[SYNC_STAGES-1][0];
      gp_q     <= stg[SYNC_STAGES-1];
    end
  end

  assign pins_s   = stg[SYNC_STAGES-1];
  assign fall_stb = clk_prev & ~pins_s[0];

  // R3
  fall_once_chk: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !fall_stb);

endmodule

// File: rtl/rxs_shift.sv
module rxs_shift
  import rxs_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall_stb,
  input  logic                 gpio_mode,
  input  logic                 fs_s,
  input  logic                 dat_s,
  input  logic [1:0]           delay_sel,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] word_q,
  output logic                 sync_err
);

  localparam int CW = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  rx_state_t            state;
  logic [WORD_BITS-1:0] sh;
  logic [WORD_BITS-1:0] sh_in;
  logic [CW-1:0]        cnt;
  logic [1:0]           wait_cnt;
  logic                 fs_prev;
  logic                 active_stb;
  logic                 fs_start;
  logic [1:0]           dly;

  assign sh_in      = {sh[WORD_BITS-2:0], dat_s};
  assign active_stb = fall_stb & ~gpio_mode;
  assign fs_start   = fs_s & ~fs_prev;
  assign dly        = eff_delay(delay_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sh        <= '0;
      cnt       <= '0;
      wait_cnt  <= '0;
      fs_prev   <= 1'b0;
      word_done <= 1'b0;
      word_q    <= '0;
      sync_err  <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (active_stb) begin
        fs_prev <= fs_s;
        if (fs_start) begin
          if (state != ST_IDLE) sync_err <= 1'b1;
          if (dly == 2'd0) begin
            sh    <= sh_in;
            cnt   <= CW'(1);
            state <= ST_DATA;
          end else begin
            wait_cnt <= dly;
            cnt      <= '0;
            state    <= ST_DELAY;
          end
        end else begin
          case (state)
            ST_DELAY: begin
              if (wait_cnt == 2'd1) begin
                sh    <= sh_in;
                cnt   <= CW'(1);
                state <= ST_DATA;
              end else begin
                wait_cnt <= wait_cnt - 2'd1;
              end
            end
            ST_DATA: begin
              sh <= sh_in;
              if (cnt == LAST) begin
                word_q    <= sh_in;
                word_done <= 1'b1;
                cnt       <= '0;
                state     <= ST_IDLE;
              end else begin
                cnt <= cnt + CW'(1);
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R2
  done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(fall_stb));

  // R9
  sync_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> sync_err);

  // R10
  gpio_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    gpio_mode |=> !word_done);

endmodule

// File: rtl/rxs_buffer.sv
module rxs_buffer #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_done,
  input  logic [WORD_BITS-1:0] word_in,
  input  logic                 rd_en,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 rx_ready,
  output logic                 rx_event,
  output logic                 overrun
);

  logic [WORD_BITS-1:0] buf_q;
  logic                 buf_full;
  logic                 host_free;
  logic                 move;

  assign host_free = ~rx_ready | rd_en;
  assign move      = buf_full & host_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      rx_data  <= '0;
      rx_ready <= 1'b0;
      rx_event <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      rx_event <= 1'b0;
      if (move) begin
        rx_data  <= buf_q;
        rx_ready <= 1'b1;
        rx_event <= 1'b1;
      end else if (rd_en) begin
        rx_ready <= 1'b0;
      end

      if (word_done) begin
        if (!buf_full || move) begin
          buf_q    <= word_in;
          buf_full <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end else if (move) begin
        buf_full <= 1'b0;
      end
    end
  end

  // R6
  event_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rx_event |-> rx_ready);

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(word_done));

  // R8
  no_ovr_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && rd_en && !overrun) |=> !overrun);

endmodule

// File: rtl/rxs_receiver.sv
module rxs_receiver #(
  parameter int WORD_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_clk_pin,
  input  logic                 rx_fs_pin,
  input  logic                 rx_dat_pin,
  input  logic [1:0]           delay_sel,
  input  logic                 gpio_mode,
  input  logic                 rd_en,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 rx_ready,
  output logic                 rx_event,
  output logic                 overrun,
  output logic                 sync_err,
  output logic [2:0]           gpio_in
);

  logic [2:0]           pins_s;
  logic                 fall_stb;
  logic                 word_done;
  logic [WORD_BITS-1:0] word_q;

  rxs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pins_in  ({rx_fs_pin, rx_dat_pin, rx_clk_pin}),
    .pins_s   (pins_s),
    .fall_stb (fall_stb),
    .gp_q     (gpio_in)
  );

  rxs_shift #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .fall_stb  (fall_stb),
    .gpio_mode (gpio_mode),
    .fs_s      (pins_s[2]),
    .dat_s     (pins_s[1]),
    .delay_sel (delay_sel),
    .word_done (word_done),
    .word_q    (word_q),
    .sync_err  (sync_err)
  );

  rxs_buffer #(.WORD_BITS(WORD_BITS)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .word_in   (word_q),
    .rd_en     (rd_en),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .rx_event  (rx_event),
    .overrun   (overrun)
  );

endmodule

// File: tb/sim_rxs_receiver.sv
module sim_rxs_receiver;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rx_clk_pin = 1'b0;
  logic         rx_fs_pin  = 1'b0;
  logic         rx_dat_pin = 1'b0;
  logic [1:0]   delay_sel  = 2'd0;
  logic         gpio_mode  = 1'b0;
  logic         rd_en      = 1'b0;
  logic [W-1:0] rx_data;
  logic         rx_ready, rx_event, overrun, sync_err;
  logic [2:0]   gpio_in;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxs_receiver #(.WORD_BITS(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .rx_clk_pin(rx_clk_pin), .rx_fs_pin(rx_fs_pin),
    .rx_dat_pin(rx_dat_pin), .delay_sel(delay_sel), .gpio_mode(gpio_mode),
    .rd_en(rd_en), .rx_data(rx_data), .rx_ready(rx_ready), .rx_event(rx_event),
    .overrun(overrun), .sync_err(sync_err), .gpio_in(gpio_in)
  );

  // {delay code, word}
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'hF0}, {2'd3, 8'h81},
    {2'd0, 8'h01}, {2'd1, 8'h80}, {2'd2, 8'h5A}, {2'd0, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_clk_pin = 1'b0; rx_fs_pin = 1'b0; rx_dat_pin = 1'b0;
    rd_en = 1'b0; gpio_mode = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Data and marker change with the rising bit clock; falling edge samples.
  // With hook set, rd_en is raised for the cycle the word reaches the buffer.
  task automatic send_bit(input logic f, input logic d, input bit hook);
    @(negedge clk);
    rx_clk_pin = 1'b1; rx_fs_pin = f; rx_dat_pin = d;
    repeat (3) @(negedge clk);
    @(negedge clk);
    rx_clk_pin = 1'b0;
    if (hook) begin
      repeat (3) @(posedge clk);
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
      repeat (2) @(negedge clk);
    end else begin
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [W-1:0] w, input logic [1:0] code,
                            input int nbits, input bit hook);
    int eff = (code == 2'd3) ? 2 : int'(code);
    int total = eff + nbits;
    delay_sel = code;
    for (int p = 0; p < total; p++) begin
      logic d = (p < eff) ? ~w[W-1] : w[W-1-(p-eff)];
      send_bit(p == 0, d, hook && (p == total - 1));
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 data", rx_data, 0);
    chk("R1 ready", rx_ready, 0);
    chk("R1 event", rx_event, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 sync_err", sync_err, 0);

    // R2 R3 R4 R5: table walk
    foreach (VEC[i]) begin
      logic [1:0]   code = VEC[i][9:8];
      logic [W-1:0] w    = VEC[i][7:0];
      send_frame(w, code, W, 1'b0);
      chk("R2 ready", rx_ready, 1);
      chk(code == 2'd0 ? "R3 R4 data" : "R3 R5 data", rx_data, w);
      host_read();
      chk("R6 ready clears", rx_ready, 0);
    end
    chk("R7 no overrun yet", overrun, 0);

    // R6: two queued words come out in order
    send_frame(8'h12, 2'd1, W, 1'b0);
    send_frame(8'h34, 2'd1, W, 1'b0);
    chk("R6 first", rx_data, 8'h12);
    host_read();
    chk("R6 second", rx_data, 8'h34);
    chk("R6 ready", rx_ready, 1);
    host_read();
    chk("R6 empty", rx_ready, 0);

    // R7: third word dropped
    send_frame(8'hC1, 2'd0, W, 1'b0);
    send_frame(8'hC2, 2'd0, W, 1'b0);
    send_frame(8'hC3, 2'd0, W, 1'b0);
    chk("R7 overrun", overrun, 1);
    chk("R7 host kept", rx_data, 8'hC1);
    host_read();
    chk("R7 buffer kept", rx_data, 8'hC2);
    host_read();
    chk("R7 dropped", rx_ready, 0);

    // R8: completion coincides with a host read
    do_reset();
    send_frame(8'hD1, 2'd0, W, 1'b0);
    send_frame(8'hD2, 2'd0, W, 1'b0);
    send_frame(8'hD3, 2'd0, W, 1'b1);
    chk("R8 no overrun", overrun, 0);
    chk("R8 moved up", rx_data, 8'hD2);
    host_read();
    chk("R8 new word", rx_data, 8'hD3);
    chk("R8 ready", rx_ready, 1);
    host_read();

    // R9: marker mid-word restarts reception
    do_reset();
    send_frame(8'hE7, 2'd0, 3, 1'b0);
    chk("R9 no word yet", rx_ready, 0);
    send_frame(8'h6B, 2'd2, W, 1'b0);
    chk("R9 sync_err", sync_err, 1);
    chk("R9 word", rx_data, 8'h6B);
    chk("R9 ready", rx_ready, 1);

    // R10: pins as plain inputs, receiver silent
    do_reset();
    gpio_mode = 1'b1;
    @(negedge clk);
    rx_fs_pin = 1'b1; rx_dat_pin = 1'b0; rx_clk_pin = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 gpio_in", gpio_in, 3'b101);
    rx_fs_pin = 1'b0; rx_dat_pin = 1'b1; rx_clk_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 gpio_in", gpio_in, 3'b010);
    send_frame(8'h99, 2'd0, W, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 no word", rx_ready, 0);
    chk("R10 data", rx_data, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule